// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block sits on a byte stream of machine instructions whose lengths run from one to six bytes. It reads the first byte of each instruction, works out how many bytes the whole instruction occupies, and then tags every byte as it passes: a start flag on the opening byte, an end flag on the closing byte, and the total length on all of them. Downstream logic can then split the stream into whole instructions without knowing anything about the encoding.

Two length encodings are supported, picked by a mode input. The first places the length as a plain 3-bit number in the top bits of the opening byte. The second uses a variable prefix: short prefixes are given to the common short instructions and a longer prefix with a 2-bit count to the rare long ones. The mode only matters on an opening byte, so a mode change during an instruction applies from the next instruction on.

The block adds no storage on the data path. Valid and ready pass straight through, and the tags are formed in the same cycle as the byte they describe.

Top module: `ild_top`

## Requirements
- R1: After reset the first byte accepted is treated as the opening byte of an instruction (`out_first` = 1).
- R2: With `mode_sel` = 0, an opening byte whose bits [7:5] hold a value N from 1 to 6 starts an instruction of N bytes, and `out_len` = N.
- R3: With `mode_sel` = 0, an opening byte whose bits [7:5] are 0 or 7 raises `out_len_err` and is handled as a complete 1-byte instruction (`out_first` = `out_last` = 1, `out_len` = 1).
- R4: With `mode_sel` = 1, an opening byte with bit 7 = 0 is a 1-byte instruction.
- R5: With `mode_sel` = 1, an opening byte with bits [7:6] = 2'b10 starts a 2-byte instruction.
- R6: With `mode_sel` = 1, an opening byte with bits [7:6] = 2'b11 starts an instruction of 3 + bits[5:4] bytes (3 to 6).
- R7: `out_first` is set only on the opening byte and `out_last` only on the byte whose position equals the length; the byte after a last byte is an opening byte.
- R8: Every byte of an instruction carries the same `out_len`, which is always between 1 and 6.
- R9: Changing `mode_sel` in the middle of an instruction does not alter that instruction's length or tags; the new mode decodes the next opening byte.
- R10: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, `out_data` follows `in_data`; a byte not taken (valid without ready) leaves the position in the instruction unchanged, so no byte is lost or repeated.
- R11: `out_len_err` is never set in prefix mode or on a continuation byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Length encoding: 0 = 3-bit length field, 1 = prefix code |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | Byte opens an instruction |
| out_last | output | 1 | Byte closes an instruction |
| out_len | output | 3 | Total length of the instruction this byte belongs to |
| out_len_err | output | 1 | Opening byte carried an illegal length field |

## Verification
All tags are combinational on the presented byte, so each result is due in the same cycle the byte is offered, and the position in the instruction moves on the clock edge at which valid and ready are both high. The bench drives inputs on the falling edge, compares every output a nanosecond later against a behavioural model, and advances the model only after the rising edge on which a transfer took place. Stalls with ready low are therefore checked as repeated presentations of the same position.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAX_LEN = 6;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    typedef enum logic {
        ENC_FIXED  = 1'b0,
        ENC_PREFIX = 1'b1
    } enc_mode_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             bad;
    } len_info_t;

    // Length from a 3-bit field; 0 and 7 are out of range and fold to 1 byte.
    function automatic len_info_t decode_fixed(input logic [2:0] fld);
        len_info_t r;
        if (fld == 3'd0 || fld == 3'd7) begin
            r.len = LEN_W'(1);
            r.bad = 1'b1;
        end else begin
            r.len = LEN_W'(fld);
            r.bad = 1'b0;
        end
        return r;
    endfunction

    // Length from the frequency-weighted prefix code in the top four bits.
    function automatic len_info_t decode_prefix(input logic [3:0] top);
        len_info_t r;
        r.bad = 1'b0;
        if (!top[3])
            r.len = LEN_W'(1);
        else if (!top[2])
            r.len = LEN_W'(2);
        else
            r.len = LEN_W'(3) + LEN_W'(top[1:0]);
        return r;
    endfunction

endpackage

// File: rtl/ild_len_decode.sv
module ild_len_decode
    import ild_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  enc_mode_e         mode,
    input  logic [DATA_W-1:0] head,
    output len_info_t         info
);
    localparam int FLD_LSB = DATA_W - 3;
    localparam int PFX_LSB = DATA_W - 4;

    logic [2:0] fld;
    logic [3:0] pfx;

    assign fld = head[FLD_LSB +: 3];
    assign pfx = head[PFX_LSB +: 4];

    always_comb begin
        if (mode == ENC_FIXED)
            info = decode_fixed(fld);
        else
            info = decode_prefix(pfx);
    end
endmodule

// File: rtl/ild_pos_track.sv
module ild_pos_track
    import ild_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LEN_W-1:0] head_len,
    output logic             at_head,
    output logic             at_tail,
    output logic [LEN_W-1:0] cur_len
);
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] len_q;

    assign at_head = (left_q == '0);
    assign cur_len = at_head ? head_len : len_q;
    assign at_tail = at_head ? (head_len == LEN_W'(1)) : (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            len_q  <= LEN_W'(1);
        end else if (take) begin
            if (at_head) begin
                left_q <= head_len - LEN_W'(1);
                len_q  <= head_len;
            end else begin
                left_q <= left_q - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/ild_top.sv
module ild_top
    import ild_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_len_err
);
    len_info_t head_info;
    logic      at_head;
    logic      take;
    enc_mode_e mode;

    assign mode      = enc_mode_e'(mode_sel);
    assign take      = in_valid && out_ready;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;

    ild_len_decode #(.DATA_W(DATA_W)) u_dec (
        .mode (mode),
        .head (in_data),
        .info (head_info)
    );

    ild_pos_track u_trk (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .head_len (head_info.len),
        .at_head  (at_head),
        .at_tail  (out_last),
        .cur_len  (out_len)
    );

    assign out_first   = at_head;
    assign out_len_err = at_head && head_info.bad;
endmodule

// File: rtl/ild_checker.sv
module ild_checker
    import ild_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_sel,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_first,
    input logic              out_last,
    input logic [LEN_W-1:0]  out_len,
    input logic              out_len_err
);
    AST_STALL_KEEPS_POS: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> (out_first == $past(out_first))); // R10

    AST_ONE_BYTE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first && out_len == LEN_W'(1)) |-> out_last); // R7

    AST_HEAD_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> out_first); // R7

    AST_TAG_STEADY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_len == $past(out_len))); // R8

    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_LEN))); // R8

    AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        out_len_err |-> (out_first && out_last && out_len == LEN_W'(1))); // R3

    AST_ERR_FIXED_ONLY: assert property (@(posedge clk) disable iff (rst)
        out_len_err |-> !mode_sel); // R11
endmodule

bind ild_top ild_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ild_top_bench.sv
`timescale 1ns/1ps
module ild_top_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_sel;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_first;
    logic       out_last;
    logic [2:0] out_len;
    logic       out_len_err;

    int vectors = 0;
    int misses  = 0;
    int m_left  = 0;   // bytes still owed by the current instruction
    int m_len   = 1;
    int seed    = 7;

    always #2 clk = ~clk;

    ild_top u_ild_top (.*);

    function automatic int ref_len(input bit md, input int b, output bit err);
        int f;
        err = 0;
        if (!md) begin
            f = b / 32;
            if (f >= 1 && f <= 6) return f;
            err = 1;
            return 1;
        end
        if (b < 128) return 1;
        if (b < 192) return 2;
        return 3 + ((b / 16) % 4);
    endfunction

    task automatic step(input bit v, input int d, input bit md, input bit rdy,
                        input string tag);
        bit e_first, e_last, e_err;
        int e_len;
        @(negedge clk);
        in_valid  = v;
        in_data   = d[7:0];
        mode_sel  = md;
        out_ready = rdy;
        #1;
        if (m_left == 0) begin
            e_first = 1;
            e_len   = ref_len(md, d, e_err);
            e_last  = (e_len == 1);
        end else begin
            e_first = 0;
            e_err   = 0;
            e_len   = m_len;
            e_last  = (m_left == 1);
        end
        vectors++;
        if (out_valid !== v || in_ready !== rdy || out_data !== d[7:0] ||
            (v && (out_first !== e_first || out_last !== e_last ||
                   int'(out_len) !== e_len || out_len_err !== e_err))) begin
            misses++;
            $display("FAIL %s: got v=%0b r=%0b d=%02h f=%0b l=%0b len=%0d err=%0b, expected v=%0b r=%0b d=%02h f=%0b l=%0b len=%0d err=%0b",
                     tag, out_valid, in_ready, out_data, out_first, out_last, out_len,
                     out_len_err, v, rdy, d[7:0], e_first, e_last, e_len, e_err);
        end
        @(posedge clk);
        if (v && rdy) begin
            if (m_left == 0) begin
                m_len  = e_len;
                m_left = e_len - 1;
            end else begin
                m_left = m_left - 1;
            end
        end
    endtask

    // One instruction: head byte then continuation bytes, with optional stalls.
    task automatic insn(input bit md, input int head, input bit md_cont,
                        input bit stalls, input string tag);
        bit e;
        int n;
        n = ref_len(md, head, e);
        if (stalls) step(1, head, md, 0, "R10");
        step(1, head, md, 1, tag);
        for (int k = 1; k < n; k++) begin
            int d;
            d = $urandom(seed + k) % 256;
            if (stalls) step(1, d, md_cont, 0, "R10");
            step(1, d, md_cont, 1, tag);
        end
    endtask

    initial begin
        #200000;
        misses++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; in_data = 0; mode_sel = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset leaves the decoder at an instruction head
        step(1, 8'h40, 0, 0, "R1");
        step(0, 8'h00, 0, 1, "R1");
        // R2: every legal fixed length
        for (int n = 1; n <= 6; n++) insn(0, n * 32 + 5, 0, 0, "R2");
        // R3: illegal fields 0 and 7
        insn(0, 8'h1f, 0, 0, "R3");
        insn(0, 8'he3, 0, 0, "R3");
        insn(0, 8'h00, 0, 1, "R3");
        // R4, R5, R6: prefix classes
        insn(1, 8'h3c, 1, 0, "R4");
        insn(1, 8'h7f, 1, 0, "R4");
        insn(1, 8'h80, 1, 0, "R5");
        insn(1, 8'hbf, 1, 1, "R5");
        for (int x = 0; x < 4; x++) insn(1, 8'hc0 + x * 16, 1, 0, "R6");
        // R11: bytes that would be illegal in fixed mode are fine in prefix mode
        insn(1, 8'hff, 1, 0, "R11");
        insn(1, 8'h05, 1, 0, "R11");
        // R7 and R8: longest instruction with stalls between bytes
        insn(0, 8'hc1, 0, 1, "R7");
        insn(1, 8'hf2, 1, 1, "R8");
        // R9: mode flips during an instruction
        insn(0, 8'h80, 1, 0, "R9");
        insn(1, 8'he0, 0, 0, "R9");
        insn(1, 8'h10, 0, 0, "R9");
        // R10: random stream with random valid, ready and mode
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom(seed * 31 + i);
            step(r[0] | r[1], (r >> 8) % 256, r[4], r[2] | r[3], "R10");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule